// File: doc/BRIEF.md
# Memory-Side Operation Decoder

This block belongs in the decode stage of a five-stage 32-bit integer pipeline. It looks at each fetched instruction. It picks out the memory-side compute operations that are hidden inside the load encoding. For each one it produces the control set for a processing unit placed next to data memory: an enable, an operation select, one or two effective addresses, and a small immediate operand.

The 12-bit load immediate is treated as two 6-bit word offsets. One instruction can therefore name two memory words, or one memory word plus a short constant. Both offsets are taken relative to the rs1 register value. The rest of the pipeline sees a word load. A pipeline-control output steers the instruction down the load path with no added stall. A load-class flag keeps the main control from raising an illegal-instruction trap.

Ordinary loads and all other instructions leave the memory-side enable low, so the core behaves exactly as an unmodified one. All outputs pass through one register stage and appear one clock after the instruction is presented. This is the decode-to-execute boundary.

Top module: `mop_decode`

## Requirements
- R1: While rst_n is low, and at the first sample after it, every output is 0.
- R2: Outputs change only at a rising clock edge. They reflect the instr_i and rs1_val_i values present at that edge, so the latency is one cycle.
- R3: Operation encoding. Opcode bits [6:0]=0000011 with funct3 bits [14:12] of 011 give op_sel 0 (memory add). The same opcode with funct3 110 gives op_sel 1 (memory multiply), and with funct3 111 gives op_sel 2 (shift left). Opcode 0001011 with funct3 000 gives op_sel 3 (add immediate). Each of these drives mop_en_o high.
- R4: For every memory-side operation, addr_a_o = rs1 + 4 × sign-extended instr[25:20]. The byte offsets reached run from −128 to +124.
- R5: For add and multiply, addr_b_o = rs1 + 4 × sign-extended instr[31:26], and imm_b_o is 0.
- R6: For the shift operation, imm_b_o holds instr[30:26] zero-extended, so bit 31 is ignored. addr_b_o is 0.
- R7: For add immediate, imm_b_o is instr[31:26] sign-extended to 32 bits, and addr_b_o is 0.
- R8: ld_path_o is 1 exactly when mop_en_o is 1.
- R9: ld_class_o is 1 for every memory-side operation, and for opcode 0000011 with funct3 000, 001, 010, 100 or 101. It is 0 for everything else.
- R10: When the instruction is not a memory-side operation, mop_en_o, op_sel_o, addr_a_o, addr_b_o and imm_b_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Fetched instruction word |
| rs1_val_i | input | XLEN | Value read from register rs1 |
| mop_en_o | output | 1 | Memory-side operation enable |
| op_sel_o | output | 2 | Operation select (0 add, 1 mul, 2 shift, 3 add-imm) |
| addr_a_o | output | XLEN | First operand byte address |
| addr_b_o | output | XLEN | Second operand byte address (two-memory ops) |
| imm_b_o | output | XLEN | Immediate second operand (single-memory ops) |
| ld_path_o | output | 1 | Force the instruction down the word-load path |
| ld_class_o | output | 1 | Instruction belongs to the load class |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a word scale of 2 (offsets ×4), and the second major opcode 0001011. With these settings the full ±32-word offset range, every funct3 code under both opcodes, and shift fields with the top bit set can all be reached by directed vectors. Random instruction words, biased towards the two major opcodes and paired with random base values, cover address wrap-around past 2^32 and all mixes of offset signs.

// File: rtl/mopd_pkg.sv
package mopd_pkg;

    localparam int INSTR_W = 32;
    localparam int OFF_W   = 6;
    localparam int F3_W    = 3;
    localparam int OPC_W   = 7;

    localparam logic [OPC_W-1:0] OPC_LOAD = 7'b0000011;

    typedef enum logic [1:0] {
        MOP_ADD  = 2'd0,
        MOP_MUL  = 2'd1,
        MOP_SHL  = 2'd2,
        MOP_ADDI = 2'd3
    } mop_op_e;

endpackage

// File: rtl/mopd_fields.sv
module mopd_fields
    import mopd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [OPC_W-1:0]   opcode,
    output logic [F3_W-1:0]    funct3,
    output logic [OFF_W-1:0]   off_lo,
    output logic [OFF_W-1:0]   off_hi
);
    // Field positions follow the standard I-type layout.
    logic unused_bits;

    always_comb begin
        opcode      = instr[6:0];
        funct3      = instr[14:12];
        off_lo      = instr[20 +: OFF_W];
        off_hi      = instr[20 + OFF_W +: OFF_W];
        unused_bits = ^{instr[11:7], instr[19:15]};
    end
endmodule

// File: rtl/mopd_opdec.sv
module mopd_opdec
    import mopd_pkg::*;
#(
    parameter logic [OPC_W-1:0] ALT_OPCODE = 7'b0001011
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [F3_W-1:0]  funct3,
    output logic             hit,
    output mop_op_e          op,
    output logic             two_mem,
    output logic             std_load
);
    always_comb begin
        hit      = 1'b0;
        op       = MOP_ADD;
        std_load = 1'b0;
        if (opcode == OPC_LOAD) begin
            unique case (funct3)
                3'b011:  begin hit = 1'b1; op = MOP_ADD; end
                3'b110:  begin hit = 1'b1; op = MOP_MUL; end
                3'b111:  begin hit = 1'b1; op = MOP_SHL; end
                default: std_load = 1'b1;
            endcase
        end else if (opcode == ALT_OPCODE && funct3 == 3'b000) begin
            hit = 1'b1;
            op  = MOP_ADDI;
        end
        two_mem = hit && (op == MOP_ADD || op == MOP_MUL);
    end
endmodule

// File: rtl/mopd_agen.sv
module mopd_agen #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 6,
    parameter int SCALE = 2
) (
    input  logic             use_lane,
    input  logic [XLEN-1:0]  base,
    input  logic [OFF_W-1:0] offset,
    output logic [XLEN-1:0]  addr
);
    localparam int EXT_W = XLEN - OFF_W;

    logic [XLEN-1:0] byte_off;

    always_comb begin
        byte_off = {{EXT_W{offset[OFF_W-1]}}, offset} << SCALE;
        addr     = use_lane ? (base + byte_off) : '0;
    end
endmodule

// File: rtl/mop_decode.sv
module mop_decode
    import mopd_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter int               SCALE      = 2,
    parameter logic [OPC_W-1:0] ALT_OPCODE = 7'b0001011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [XLEN-1:0]    rs1_val_i,
    output logic               mop_en_o,
    output logic [1:0]         op_sel_o,
    output logic [XLEN-1:0]    addr_a_o,
    output logic [XLEN-1:0]    addr_b_o,
    output logic [XLEN-1:0]    imm_b_o,
    output logic               ld_path_o,
    output logic               ld_class_o
);
    localparam int SH_W   = $clog2(XLEN);
    localparam int N_LANE = 2;

    typedef struct packed {
        logic            en;
        mop_op_e         sel;
        logic [XLEN-1:0] addr_a;
        logic [XLEN-1:0] addr_b;
        logic [XLEN-1:0] imm_b;
        logic            ld_path;
        logic            ld_class;
    } ctl_t;

    logic [OPC_W-1:0] opcode;
    logic [F3_W-1:0]  funct3;
    logic [OFF_W-1:0] off_lo, off_hi;
    logic             hit, two_mem, std_load;
    mop_op_e          op;

    mopd_fields u_fields (
        .instr  (instr_i),
        .opcode (opcode),
        .funct3 (funct3),
        .off_lo (off_lo),
        .off_hi (off_hi)
    );

    mopd_opdec #(.ALT_OPCODE(ALT_OPCODE)) u_opdec (
        .opcode   (opcode),
        .funct3   (funct3),
        .hit      (hit),
        .op       (op),
        .two_mem  (two_mem),
        .std_load (std_load)
    );

    logic [N_LANE-1:0]            lane_use;
    logic [N_LANE-1:0][OFF_W-1:0] lane_off;
    logic [N_LANE-1:0][XLEN-1:0]  lane_addr;

    always_comb begin
        lane_use[0] = hit;
        lane_use[1] = two_mem;
        lane_off[0] = off_lo;
        lane_off[1] = off_hi;
    end

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        mopd_agen #(.XLEN(XLEN), .OFF_W(OFF_W), .SCALE(SCALE)) u_agen (
            .use_lane (lane_use[g]),
            .base     (rs1_val_i),
            .offset   (lane_off[g]),
            .addr     (lane_addr[g])
        );
    end

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d          = '0;
        ctl_d.en       = hit;
        ctl_d.sel      = hit ? op : MOP_ADD;
        ctl_d.addr_a   = lane_addr[0];
        ctl_d.addr_b   = lane_addr[1];
        ctl_d.ld_path  = hit;
        ctl_d.ld_class = hit | std_load;
        if (hit && op == MOP_SHL)
            ctl_d.imm_b = {{(XLEN-SH_W){1'b0}}, off_hi[SH_W-1:0]};
        else if (hit && op == MOP_ADDI)
            ctl_d.imm_b = {{(XLEN-OFF_W){off_hi[OFF_W-1]}}, off_hi};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mop_en_o   = ctl_q.en;
    assign op_sel_o   = ctl_q.sel;
    assign addr_a_o   = ctl_q.addr_a;
    assign addr_b_o   = ctl_q.addr_b;
    assign imm_b_o    = ctl_q.imm_b;
    assign ld_path_o  = ctl_q.ld_path;
    assign ld_class_o = ctl_q.ld_class;
endmodule

// File: rtl/mop_decode_chk.sv
module mop_decode_chk #(
    parameter int XLEN  = 32,
    parameter int SCALE = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] rs1_val_i,
    input logic            mop_en_o,
    input logic [1:0]      op_sel_o,
    input logic [XLEN-1:0] addr_a_o,
    input logic [XLEN-1:0] addr_b_o,
    input logic [XLEN-1:0] imm_b_o,
    input logic            ld_path_o,
    input logic            ld_class_o
);
    // R9
    en_implies_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mop_en_o |-> ld_class_o);

    // R8
    path_tracks_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_path_o == mop_en_o);

    // R10
    idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mop_en_o |-> (op_sel_o == 2'd0 && addr_a_o == '0 && addr_b_o == '0 && imm_b_o == '0));

    // R6
    shift_amount_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mop_en_o && op_sel_o == 2'd2) |-> (imm_b_o < XLEN && addr_b_o == '0));

    // R7
    addi_no_second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mop_en_o && op_sel_o == 2'd3) |-> addr_b_o == '0);

    // R5
    two_mem_no_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mop_en_o && op_sel_o[1] == 1'b0) |-> imm_b_o == '0);

    // R4
    word_offset_keeps_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mop_en_o |-> addr_a_o[SCALE-1:0] == $past(rs1_val_i[SCALE-1:0]));
endmodule

bind mop_decode mop_decode_chk #(.XLEN(XLEN), .SCALE(SCALE)) u_mop_decode_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rs1_val_i  (rs1_val_i),
    .mop_en_o   (mop_en_o),
    .op_sel_o   (op_sel_o),
    .addr_a_o   (addr_a_o),
    .addr_b_o   (addr_b_o),
    .imm_b_o    (imm_b_o),
    .ld_path_o  (ld_path_o),
    .ld_class_o (ld_class_o)
);

// File: tb/mop_decode_bench.sv
module mop_decode_bench;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     instr_i = '0;
    logic [XLEN-1:0] rs1_val_i = '0;
    logic            mop_en_o, ld_path_o, ld_class_o;
    logic [1:0]      op_sel_o;
    logic [XLEN-1:0] addr_a_o, addr_b_o, imm_b_o;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mop_decode u_mop_decode (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .rs1_val_i(rs1_val_i),
        .mop_en_o(mop_en_o), .op_sel_o(op_sel_o), .addr_a_o(addr_a_o),
        .addr_b_o(addr_b_o), .imm_b_o(imm_b_o), .ld_path_o(ld_path_o),
        .ld_class_o(ld_class_o)
    );

    // Reference model taken from the requirements.
    typedef struct {
        logic        en;
        logic [1:0]  sel;
        logic [31:0] a, b, imm;
        logic        path, cls;
    } exp_t;

    function automatic exp_t model(input logic [31:0] ins, input logic [31:0] base);
        exp_t e;
        int   lo, hi;
        e = '{en: 0, sel: 0, a: 0, b: 0, imm: 0, path: 0, cls: 0};
        lo = int'($signed(ins[25:20]));
        hi = int'($signed(ins[31:26]));
        if (ins[6:0] == 7'b0000011) begin
            case (ins[14:12])
                3'b011: begin e.en = 1; e.sel = 0; end
                3'b110: begin e.en = 1; e.sel = 1; end
                3'b111: begin e.en = 1; e.sel = 2; end
                default: e.cls = 1;
            endcase
        end else if (ins[6:0] == 7'b0001011 && ins[14:12] == 3'b000) begin
            e.en = 1; e.sel = 3;
        end
        if (e.en) begin
            e.cls  = 1;
            e.path = 1;
            e.a    = base + 32'(lo * 4);
            if (e.sel < 2) e.b = base + 32'(hi * 4);
            else if (e.sel == 2) e.imm = 32'(ins[30:26]);
            else e.imm = 32'(hi);
        end
        return e;
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] hi, input logic [5:0] lo,
                                       input logic [2:0] f3, input logic [6:0] opc);
        return {hi, lo, 5'd9, f3, 5'd15, opc};
    endfunction

    task automatic compare(input string req, input exp_t e);
        bit bad = 0;
        n_vec++;
        if (mop_en_o !== e.en)     begin bad = 1; $display("FAIL %s en act=%0b exp=%0b", req, mop_en_o, e.en); end
        if (op_sel_o !== e.sel)    begin bad = 1; $display("FAIL %s sel act=%0d exp=%0d", req, op_sel_o, e.sel); end
        if (addr_a_o !== e.a)      begin bad = 1; $display("FAIL %s addr_a act=%h exp=%h", req, addr_a_o, e.a); end
        if (addr_b_o !== e.b)      begin bad = 1; $display("FAIL %s addr_b act=%h exp=%h", req, addr_b_o, e.b); end
        if (imm_b_o !== e.imm)     begin bad = 1; $display("FAIL %s imm act=%h exp=%h", req, imm_b_o, e.imm); end
        if (ld_path_o !== e.path)  begin bad = 1; $display("FAIL %s R8 ld_path act=%0b exp=%0b", req, ld_path_o, e.path); end
        if (ld_class_o !== e.cls)  begin bad = 1; $display("FAIL %s R9 ld_class act=%0b exp=%0b", req, ld_class_o, e.cls); end
        if (bad) n_bad++;
    endtask

    // Drive at falling edge, sample at next falling edge (one register stage).
    task automatic apply(input string req, input logic [31:0] ins, input logic [31:0] base);
        exp_t e;
        @(negedge clk);
        instr_i   = ins;
        rs1_val_i = base;
        e = model(ins, base);
        @(negedge clk);
        compare(req, e);
    endtask

    exp_t zero_e;

    initial begin
        void'($urandom(32'h5eed_0042));
        zero_e = '{en: 0, sel: 0, a: 0, b: 0, imm: 0, path: 0, cls: 0};

        // R1: reset holds outputs at zero even with an active instruction present.
        instr_i   = mk(6'd3, 6'd2, 3'b011, 7'b0000011);
        rs1_val_i = 32'h1000;
        repeat (3) @(negedge clk);
        compare("R1", zero_e);
        rst_n = 1'b1;
        instr_i = '0;
        rs1_val_i = '0;
        @(negedge clk);
        compare("R1", zero_e);

        // R2: output follows the input one edge later, not before.
        @(negedge clk);
        instr_i   = mk(6'd1, 6'd1, 3'b110, 7'b0000011);
        rs1_val_i = 32'h200;
        #1 compare("R2", zero_e);
        @(negedge clk);
        compare("R2", model(instr_i, rs1_val_i));

        // R3: each operation code.
        apply("R3", mk(6'd2, 6'd1, 3'b011, 7'b0000011), 32'h4000);
        apply("R3", mk(6'd2, 6'd1, 3'b110, 7'b0000011), 32'h4000);
        apply("R3", mk(6'd2, 6'd1, 3'b111, 7'b0000011), 32'h4000);
        apply("R3", mk(6'd2, 6'd1, 3'b000, 7'b0001011), 32'h4000);

        // R4/R5: offset extremes -128 and +124 bytes.
        apply("R4", mk(6'h1f, 6'h20, 3'b011, 7'b0000011), 32'h0000_1000);
        apply("R5", mk(6'h20, 6'h1f, 3'b110, 7'b0000011), 32'h0000_1000);
        apply("R5", mk(6'h3f, 6'h3f, 3'b011, 7'b0000011), 32'h0000_0000);
        apply("R4", mk(6'h00, 6'h1f, 3'b011, 7'b0000011), 32'hffff_fff0);

        // R6: bit 31 of the field is ignored for the shift amount.
        apply("R6", mk(6'h3f, 6'd0, 3'b111, 7'b0000011), 32'h80);
        apply("R6", mk(6'h25, 6'd4, 3'b111, 7'b0000011), 32'h80);

        // R7: add-immediate sign extension.
        apply("R7", mk(6'h20, 6'd0, 3'b000, 7'b0001011), 32'h80);
        apply("R7", mk(6'h1f, 6'h3e, 3'b000, 7'b0001011), 32'h80);

        // R9/R10: standard loads keep their meaning, other encodings stay idle.
        foreach (zero_e.sel[i]) begin end
        for (int f = 0; f < 8; f++)
            apply("R9", mk(6'h11, 6'h22, 3'(f), 7'b0000011), 32'h3000);
        for (int f = 1; f < 8; f++)
            apply("R10", mk(6'h11, 6'h22, 3'(f), 7'b0001011), 32'h3000);
        apply("R10", 32'h00f7_02b3, 32'h3000);
        apply("R10", mk(6'h11, 6'h22, 3'b011, 7'b0100011), 32'h3000);

        // R8: random mix, biased towards the two major opcodes.
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] ins;
            int          pick;
            ins  = $urandom;
            pick = int'($urandom_range(0, 3));
            if (pick == 0)      ins[6:0] = 7'b0000011;
            else if (pick == 1) ins[6:0] = 7'b0001011;
            else if (pick == 2) ins[14:12] = 3'b011;
            if (pick == 1 && $urandom_range(0, 1) == 1) ins[14:12] = 3'b000;
            if (pick == 2) ins[6:0] = 7'b0000011;
            apply("R8", ins, $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule